// File: doc/BRIEF.md
# Predicated Source/Destination Step Sequencer

This block schedules the element indices of a vector loop driven by one shared predicate mask. After a start strobe it captures a vector length, the mask and two zeroing flags, one for the source side and one for the destination side. It then issues a stream of index pairs (source step, destination step), one pair per accepted transfer. Bit i of the mask belongs to element i, for source and destination alike.

A side whose zeroing flag is clear visits only the elements whose mask bit is 1. A side whose zeroing flag is set visits every element in turn. Both steps advance together on every accepted pair, so the two indices drift apart whenever the flags differ. With each pair the block also says whether the destination element has to be written as zero. The loop ends as soon as either side has no eligible element left below the vector length.

The pair stream is valid/ready. A pair is transferred on a clock edge where `pair_valid` and `pair_ready` are both high. While `pair_valid` is high and `pair_ready` is low, the pair is held unchanged. `pair_valid` never drops without a transfer, except when the loop ends. `seq_busy` and `seq_done` are plain status pins.

Top module: `pred_step_seq`

## Requirements
- R1: A start strobe sampled while idle captures length, mask and flags. A strobe, or any change on those inputs, while `seq_busy` is high has no effect on the running sequence.
- R2: With the effective source zeroing flag clear, the k-th issued source index is the k-th index below VL whose mask bit is 1. With the flag set, it is k.
- R3: With the effective destination zeroing flag clear, the k-th issued destination index is the k-th index below VL whose mask bit is 1. With the flag set, it is k.
- R4: Both indices advance on every accepted pair, in strictly increasing order. When the two effective flags are equal, the indices are equal.
- R5: The number of pairs issued is the smaller of the two sides' eligible-element counts. After the last pair, `seq_done` pulses high for exactly one cycle with `pair_valid` low, and `seq_busy` falls.
- R6: `pair_zero` is 1 exactly when the effective destination zeroing flag is set and the mask bit at the issued destination index is 0.
- R7: When `zz_sel` is 1, `zz_flag` drives both effective zeroing flags and the separate flags are ignored. When `zz_sel` is 0, `src_zero` and `dst_zero` apply.
- R8: While `pair_valid` is high and `pair_ready` is low, the pair (source index, destination index, zero flag) stays stable and valid.
- R9: When either side has no eligible element (VL of 0, or an all-zero mask below VL on a side whose flag is clear), `seq_done` pulses without any pair being issued. Mask bits at or above VL are ignored.
- R10: After reset, `pair_valid`, `seq_busy` and `seq_done` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, captured while idle |
| cfg_vl | input | VLW (7) | Vector length, clamped to MAX_VL |
| cfg_mask | input | MAX_VL (64) | Predicate mask, bit i for element i |
| src_zero | input | 1 | Source zeroing flag |
| dst_zero | input | 1 | Destination zeroing flag |
| zz_sel | input | 1 | Use combined zeroing flag |
| zz_flag | input | 1 | Combined zeroing flag value |
| pair_valid | output | 1 | Index pair available |
| pair_ready | input | 1 | Downstream accepts the pair |
| pair_src | output | IW (6) | Source element index |
| pair_dst | output | IW (6) | Destination element index |
| pair_zero | output | 1 | Destination element must be written as zero |
| seq_busy | output | 1 | A loop is in progress |
| seq_done | output | 1 | One-cycle pulse when the loop ends |

## Verification
The hardest states to reach are the ones where the two steps diverge far enough that one side runs out first. One case is a 64-element loop with alternating mask bits and only one side zeroing, so the source list ends after 32 pairs while the destination still has elements left. The other case is a mask with bits set only at or above VL. A table of configurations walks these cases against an index model in the bench. Each run has a repeating ready pattern that stalls every third cycle, so hold behaviour is exercised on every run. Directed runs then strobe start with a different configuration mid-loop and exercise the combined flag.

// File: rtl/pred_step_pkg.sv
package pred_step_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  // Pick the combined zeroing flag when selected, else the side's own flag.
  function automatic logic pick_zero(input logic use_comb, input logic comb,
                                     input logic own);
    return use_comb ? comb : own;
  endfunction

endpackage

// File: rtl/pred_step_cfg.sv
module pred_step_cfg
  import pred_step_pkg::*;
#(
  parameter int MAX_VL = 64,
  localparam int VLW = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [VLW-1:0]    vl_in,
  input  logic [MAX_VL-1:0] mask_in,
  input  logic              sz_in,
  input  logic              dz_in,
  input  logic              zsel_in,
  input  logic              zz_in,
  output logic [VLW-1:0]    lat_vl,
  output logic [MAX_VL-1:0] lat_mask,
  output logic              lat_sz,
  output logic              lat_dz
);

  localparam logic [VLW-1:0] VL_CAP = VLW'(MAX_VL);

  logic [VLW-1:0] vl_clamped;

  assign vl_clamped = (vl_in > VL_CAP) ? VL_CAP : vl_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_vl   <= '0;
      lat_mask <= '0;
      lat_sz   <= 1'b0;
      lat_dz   <= 1'b0;
    end else if (load) begin
      lat_vl   <= vl_clamped;
      lat_mask <= mask_in;
      lat_sz   <= pick_zero(zsel_in, zz_in, sz_in);
      lat_dz   <= pick_zero(zsel_in, zz_in, dz_in);
    end
  end

endmodule

// File: rtl/pred_step_finder.sv
module pred_step_finder #(
  parameter int MAX_VL = 64,
  localparam int VLW = $clog2(MAX_VL + 1),
  localparam int IW  = $clog2(MAX_VL)
) (
  input  logic [MAX_VL-1:0] mask,
  input  logic              zeroing,
  input  logic [VLW-1:0]    vl,
  input  logic [VLW-1:0]    from,
  output logic              found,
  output logic [IW-1:0]     idx
);

  logic [MAX_VL-1:0] elig;

  // Element is a candidate if the side visits it, it is inside the
  // vector and it is not behind the current search point.
  for (genvar g = 0; g < MAX_VL; g++) begin : g_elig
    assign elig[g] = (zeroing | mask[g]) &
                     (VLW'(g) < vl) &
                     (VLW'(g) >= from);
  end

  // Lowest candidate wins.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = MAX_VL - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/pred_step_ctrl.sv
module pred_step_ctrl
  import pred_step_pkg::*;
#(
  parameter int MAX_VL = 64,
  localparam int VLW = $clog2(MAX_VL + 1),
  localparam int IW  = $clog2(MAX_VL)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           src_found,
  input  logic [IW-1:0]  src_idx,
  input  logic           dst_found,
  input  logic [IW-1:0]  dst_idx,
  input  logic           out_ready,
  output logic           load,
  output logic [VLW-1:0] from_src,
  output logic [VLW-1:0] from_dst,
  output logic           out_valid,
  output logic           busy,
  output logic           done
);

  seq_state_e state;
  logic       both_found;
  logic       fire;

  assign both_found = src_found & dst_found;
  assign load       = (state == SEQ_IDLE) & start;
  assign busy       = (state == SEQ_RUN);
  assign out_valid  = busy & both_found;
  assign fire       = out_valid & out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      from_src <= '0;
      from_dst <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        SEQ_IDLE: begin
          if (start) begin
            state    <= SEQ_RUN;
            from_src <= '0;
            from_dst <= '0;
          end
        end
        SEQ_RUN: begin
          if (!both_found) begin
            state <= SEQ_IDLE;
            done  <= 1'b1;
          end else if (fire) begin
            from_src <= VLW'(src_idx) + VLW'(1);
            from_dst <= VLW'(dst_idx) + VLW'(1);
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pred_step_seq.sv
module pred_step_seq
  import pred_step_pkg::*;
#(
  parameter int MAX_VL = 64,
  localparam int VLW = $clog2(MAX_VL + 1),
  localparam int IW  = $clog2(MAX_VL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VLW-1:0]    cfg_vl,
  input  logic [MAX_VL-1:0] cfg_mask,
  input  logic              src_zero,
  input  logic              dst_zero,
  input  logic              zz_sel,
  input  logic              zz_flag,
  output logic              pair_valid,
  input  logic              pair_ready,
  output logic [IW-1:0]     pair_src,
  output logic [IW-1:0]     pair_dst,
  output logic              pair_zero,
  output logic              seq_busy,
  output logic              seq_done
);

  localparam int SIDES = 2; // 0 = source, 1 = destination

  logic              load;
  logic [VLW-1:0]    lat_vl;
  logic [MAX_VL-1:0] lat_mask;
  logic              lat_sz;
  logic              lat_dz;

  logic [VLW-1:0]    side_from  [SIDES];
  logic              side_zero  [SIDES];
  logic              side_found [SIDES];
  logic [IW-1:0]     side_idx   [SIDES];

  pred_step_cfg #(.MAX_VL(MAX_VL)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .vl_in    (cfg_vl),
    .mask_in  (cfg_mask),
    .sz_in    (src_zero),
    .dz_in    (dst_zero),
    .zsel_in  (zz_sel),
    .zz_in    (zz_flag),
    .lat_vl   (lat_vl),
    .lat_mask (lat_mask),
    .lat_sz   (lat_sz),
    .lat_dz   (lat_dz)
  );

  assign side_zero[0] = lat_sz;
  assign side_zero[1] = lat_dz;

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    pred_step_finder #(.MAX_VL(MAX_VL)) u_find (
      .mask    (lat_mask),
      .zeroing (side_zero[s]),
      .vl      (lat_vl),
      .from    (side_from[s]),
      .found   (side_found[s]),
      .idx     (side_idx[s])
    );
  end

  pred_step_ctrl #(.MAX_VL(MAX_VL)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .src_found (side_found[0]),
    .src_idx   (side_idx[0]),
    .dst_found (side_found[1]),
    .dst_idx   (side_idx[1]),
    .out_ready (pair_ready),
    .load      (load),
    .from_src  (side_from[0]),
    .from_dst  (side_from[1]),
    .out_valid (pair_valid),
    .busy      (seq_busy),
    .done      (seq_done)
  );

  assign pair_src  = side_idx[0];
  assign pair_dst  = side_idx[1];
  assign pair_zero = pair_valid & lat_dz & ~lat_mask[side_idx[1]];

endmodule

// File: rtl/pred_step_seq_chk.sv
module pred_step_seq_chk #(
  parameter int MAX_VL = 64,
  localparam int VLW = $clog2(MAX_VL + 1),
  localparam int IW  = $clog2(MAX_VL)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pair_valid,
  input logic              pair_ready,
  input logic [IW-1:0]     pair_src,
  input logic [IW-1:0]     pair_dst,
  input logic              pair_zero,
  input logic              seq_busy,
  input logic              seq_done,
  input logic [VLW-1:0]    lat_vl,
  input logic [MAX_VL-1:0] lat_mask,
  input logic              lat_sz,
  input logic              lat_dz
);

  assert_src_skip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid && !lat_sz |-> lat_mask[pair_src]);

  assert_dst_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid && !lat_dz |-> lat_mask[pair_dst] && !pair_zero);

  assert_ascend_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid && pair_ready |=> !pair_valid ||
      (pair_src > $past(pair_src) && pair_dst > $past(pair_dst)));

  assert_lockstep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid && (lat_sz == lat_dz) |-> pair_src == pair_dst);

  assert_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> ({1'b0, pair_src} < lat_vl) && ({1'b0, pair_dst} < lat_vl));

  assert_done_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> !pair_valid && !seq_busy);

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

  assert_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pair_zero |-> pair_valid && lat_dz && !lat_mask[pair_dst]);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid && !pair_ready |=> pair_valid && $stable(pair_src) &&
      $stable(pair_dst) && $stable(pair_zero));

endmodule

bind pred_step_seq pred_step_seq_chk #(.MAX_VL(MAX_VL)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pair_valid (pair_valid),
  .pair_ready (pair_ready),
  .pair_src   (pair_src),
  .pair_dst   (pair_dst),
  .pair_zero  (pair_zero),
  .seq_busy   (seq_busy),
  .seq_done   (seq_done),
  .lat_vl     (lat_vl),
  .lat_mask   (lat_mask),
  .lat_sz     (lat_sz),
  .lat_dz     (lat_dz)
);

// File: tb/test_pred_step_seq.sv
`timescale 1ns/1ps
module test_pred_step_seq;

  localparam int MAX_VL = 64;
  localparam int VLW = 7;
  localparam int IW  = 6;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic [VLW-1:0]    cfg_vl;
  logic [MAX_VL-1:0] cfg_mask;
  logic              src_zero, dst_zero, zz_sel, zz_flag;
  logic              pair_valid, pair_ready;
  logic [IW-1:0]     pair_src, pair_dst;
  logic              pair_zero, seq_busy, seq_done;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pred_step_seq #(.MAX_VL(MAX_VL)) i_pred_step_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_vl(cfg_vl),
    .cfg_mask(cfg_mask), .src_zero(src_zero), .dst_zero(dst_zero),
    .zz_sel(zz_sel), .zz_flag(zz_flag), .pair_valid(pair_valid),
    .pair_ready(pair_ready), .pair_src(pair_src), .pair_dst(pair_dst),
    .pair_zero(pair_zero), .seq_busy(seq_busy), .seq_done(seq_done)
  );

  typedef struct packed {
    logic [6:0]  vl;
    logic [63:0] m;
    logic        sz;
    logic        dz;
    logic [6:0]  cnt;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{7'd4,  64'hD,                   1'b0, 1'b0, 7'd3},
    '{7'd4,  64'hD,                   1'b0, 1'b1, 7'd3},
    '{7'd4,  64'hD,                   1'b1, 1'b0, 7'd3},
    '{7'd4,  64'hD,                   1'b1, 1'b1, 7'd4},
    '{7'd8,  64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 7'd8},
    '{7'd64, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0, 1'b1, 7'd32},
    '{7'd0,  64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 7'd0},
    '{7'd4,  64'h0,                   1'b0, 1'b0, 7'd0},
    '{7'd4,  64'h0,                   1'b1, 1'b0, 7'd0},
    '{7'd5,  64'h10,                  1'b0, 1'b0, 7'd1},
    '{7'd64, 64'h8000_0000_0000_0001, 1'b0, 1'b0, 7'd2},
    '{7'd3,  64'hF0,                  1'b0, 1'b1, 7'd0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Index model: n-th element visited by a side, or -1.
  function automatic int nth(input logic [63:0] m, input int vl,
                             input bit z, input int n);
    int cnt = 0;
    for (int i = 0; i < vl && i < 64; i++) begin
      if (z || m[i]) begin
        if (cnt == n) return i;
        cnt++;
      end
    end
    return -1;
  endfunction

  task automatic run_case(input logic [6:0] vl, input logic [63:0] m,
                          input logic sz, input logic dz, input logic zsel,
                          input logic zz, input int exp_cnt,
                          input string tag, input bit poke);
    bit esz, edz, stalled, seen_done;
    int k, es, ed, ps, pd, pz;
    esz = zsel ? zz : sz;
    edz = zsel ? zz : dz;
    @(negedge clk);
    cfg_vl = vl; cfg_mask = m; src_zero = sz; dst_zero = dz;
    zz_sel = zsel; zz_flag = zz; start = 1'b1; pair_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    k = 0; stalled = 0; seen_done = 0; ps = 0; pd = 0; pz = 0;
    for (int c = 0; c < 400 && !seen_done; c++) begin
      if (c > 0) @(negedge clk);
      if (poke && c == 1) begin
        // R1: a new configuration and strobe while busy must be ignored
        start = 1'b1; cfg_vl = 7'd8; cfg_mask = '1;
        src_zero = 1'b1; dst_zero = 1'b1; zz_sel = 1'b0;
      end else begin
        start = 1'b0;
      end
      if (seq_done) begin
        seen_done = 1;
        chk(!pair_valid, "R5", {tag, " valid with done"}, int'(pair_valid), 0);
        pair_ready = 1'b0;
      end else if (pair_valid) begin
        if (stalled) begin
          chk(int'(pair_src) == ps && int'(pair_dst) == pd && int'(pair_zero) == pz,
              "R8", {tag, " hold src"}, int'(pair_src), ps);
        end else begin
          es = nth(m, int'(vl), esz, k);
          ed = nth(m, int'(vl), edz, k);
          chk(int'(pair_src) == es, "R2 R4", {tag, " src"}, int'(pair_src), es);
          chk(int'(pair_dst) == ed, "R3 R4", {tag, " dst"}, int'(pair_dst), ed);
          chk(int'(pair_zero) == int'(edz && ed >= 0 && !m[ed[5:0]]),
              "R6", {tag, " zero"}, int'(pair_zero),
              int'(edz && ed >= 0 && !m[ed[5:0]]));
        end
        ps = int'(pair_src); pd = int'(pair_dst); pz = int'(pair_zero);
        pair_ready = (c % 3 != 2);
        stalled = !pair_ready;
        if (pair_ready) k++;
      end else begin
        pair_ready = 1'b0;
        stalled = 0;
      end
    end
    start = 1'b0;
    chk(seen_done, "R5", {tag, " done seen"}, int'(seen_done), 1);
    chk(k == exp_cnt, "R5 R9", {tag, " pair count"}, k, exp_cnt);
    @(negedge clk);
    chk(!seq_done && !seq_busy, "R5", {tag, " done one cycle"}, int'(seq_done), 0);
    pair_ready = 1'b0;
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; cfg_vl = '0; cfg_mask = '0;
    src_zero = 1'b0; dst_zero = 1'b0; zz_sel = 1'b0; zz_flag = 1'b0;
    pair_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(!pair_valid && !seq_busy && !seq_done, "R10", "reset outputs",
        int'({pair_valid, seq_busy, seq_done}), 0);

    foreach (TBL[i])
      run_case(TBL[i].vl, TBL[i].m, TBL[i].sz, TBL[i].dz, 1'b0, 1'b0,
               int'(TBL[i].cnt), $sformatf("vec%0d R9", i), 1'b0);

    // R1: strobe and config change mid-run ignored
    run_case(7'd4, 64'hD, 1'b0, 1'b0, 1'b0, 1'b0, 3, "R1 busy start", 1'b1);
    // R7: combined flag overrides separate flags
    run_case(7'd4, 64'hD, 1'b1, 1'b1, 1'b1, 1'b0, 3, "R7 zz clear", 1'b0);
    run_case(7'd4, 64'hD, 1'b0, 1'b0, 1'b1, 1'b1, 4, "R7 zz set", 1'b0);
    // VL above maximum is clamped
    run_case(7'd100, 64'h1, 1'b0, 1'b1, 1'b0, 1'b0, 1, "R2 vl clamp", 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule